// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block carries out the exception-entry step of a small 32-bit RISC core with branch delay slots. A trap source presents a cause code with a strobe. When no trap is present, an internal arbiter may raise an entry on its own for a pending external or tick-timer interrupt. An accepted entry updates everything in one clock edge: the saved return address, the saved and new status words, the power-management bits, the load-link reservation and the redirected fetch PC. It also emits a one-cycle pulse that flushes the translation buffers.

The saved return address depends on the cause and on whether the faulting instruction sat in a delay slot. The vector address is formed by OR-ing three parts: the cause shifted left by 8, an optional base register, and an optional high-region prefix. A cause outside the defined range does not redirect; the block raises an error pulse instead. Every output is a register that holds its value between entries.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On an accepted entry, epc_o takes pc_i, or pc_i minus 4 when in_dslot_i is high. Bit 6 (delay-slot) of both esr_o and sr_o equals in_dslot_i.
- R2: For cause 12 (system call), 4 is added to the saved PC after the delay-slot adjustment.
- R3: For cause 7 (illegal instruction), eear_o takes pc_i. Every other cause leaves eear_o unchanged.
- R4: esr_o takes sr_i on entry, with only bit 6 replaced as in R1.
- R5: sr_o equals esr_o with bits 1 (timer enable), 2 (interrupt enable), 3 (data MMU) and 4 (instruction MMU) cleared and bit 0 (supervisor) set. All other bits are unchanged.
- R6: On entry, pm_o takes pm_i with bit 0 (doze) and bit 1 (sleep) cleared, and ll_addr_o becomes all ones.
- R7: pc_o becomes (cause << 8). It is OR-ed with vbase_i when vbase_en_i is high, and OR-ed with 0xF0000000 when sr_i bit 5 is high.
- R8: A cause of 0, or a cause of 15 or more, pulses unhandled_o for one cycle. entry_o and tlb_flush_o stay low and all saved registers hold.
- R9: With no trap strobe, a tick interrupt is taken as cause 5 only when sr_i bit 1 is set. An external interrupt is taken as cause 8 only when sr_i bit 2 is set. When both qualify, the tick interrupt wins.
- R10: A trap strobe takes priority over any qualifying interrupt in the same cycle. An interrupt still pending in the next cycle is then taken.
- R11: Results appear on the clock edge that samples the request. entry_o and tlb_flush_o are high for exactly the cycle after each accepted entry, and exc_cause_o shows the cause taken. All outputs reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | Trap request strobe |
| trap_cause_i | input | 5 | Trap cause code |
| irq_ext_i | input | 1 | External interrupt pending |
| irq_tick_i | input | 1 | Tick-timer interrupt pending |
| pc_i | input | 32 | PC of the current instruction |
| in_dslot_i | input | 1 | Current instruction is in a delay slot |
| sr_i | input | 16 | Current status word |
| pm_i | input | 4 | Current power-management bits |
| vbase_i | input | 32 | Vector base register |
| vbase_en_i | input | 1 | Vector base register is present |
| entry_o | output | 1 | Entry taken in the last cycle |
| unhandled_o | output | 1 | Invalid cause seen in the last cycle |
| tlb_flush_o | output | 1 | Translation-buffer flush pulse |
| exc_cause_o | output | 5 | Cause of the last entry |
| pc_o | output | 32 | Redirected fetch PC |
| epc_o | output | 32 | Saved return address |
| eear_o | output | 32 | Saved effective address |
| esr_o | output | 16 | Saved status word |
| sr_o | output | 16 | New status word |
| pm_o | output | 4 | New power-management bits |
| ll_addr_o | output | 32 | Load-link reservation address |

## Verification
Two kinds of collision are tested. In the first, a trap strobe and a qualifying interrupt arrive in the same cycle. The bench holds the interrupt high across the trap and expects the trap's cause, PC and status first, then the interrupt's entry one cycle later. In the second, both interrupt lines are pending with both enables set, and the bench expects cause 5. It then clears the timer enable alone and expects cause 8, which shows that qualification happens before the priority choice.

// File: rtl/exc_pkg.sv
package exc_pkg;
  parameter int XLEN       = 32;
  parameter int SR_W       = 16;
  parameter int PM_W       = 4;
  parameter int CAUSE_W    = 5;
  parameter int NUM_CAUSES = 15;
  parameter int VEC_SHIFT  = 8;

  parameter int SM_BIT   = 0;
  parameter int TEE_BIT  = 1;
  parameter int IEE_BIT  = 2;
  parameter int DME_BIT  = 3;
  parameter int IME_BIT  = 4;
  parameter int EPH_BIT  = 5;
  parameter int DSX_BIT  = 6;
  parameter int DOZE_BIT = 0;
  parameter int SLP_BIT  = 1;

  parameter logic [CAUSE_W-1:0] C_TICK    = 5'd5;
  parameter logic [CAUSE_W-1:0] C_ILLEGAL = 5'd7;
  parameter logic [CAUSE_W-1:0] C_EXT     = 5'd8;
  parameter logic [CAUSE_W-1:0] C_SYSCALL = 5'd12;

  parameter logic [31:0] HIGH_PREFIX = 32'hF000_0000;
endpackage

// File: rtl/exc_irq_arb.sv
module exc_irq_arb #(
  parameter int CW = 5,
  parameter logic [CW-1:0] TICK_CODE = 5,
  parameter logic [CW-1:0] EXT_CODE  = 8
) (
  input  logic          ext_i,
  input  logic          tick_i,
  input  logic          iee_i,
  input  logic          tee_i,
  output logic          req_o,
  output logic [CW-1:0] cause_o
);
  logic tick_q, ext_q;
  assign tick_q = tick_i & tee_i;
  assign ext_q  = ext_i & iee_i;
  assign req_o  = tick_q | ext_q;
  // timer wins over external
  assign cause_o = tick_q ? TICK_CODE : (ext_q ? EXT_CODE : '0);
endmodule

// File: rtl/exc_cause_chk.sv
module exc_cause_chk #(
  parameter int CW  = 5,
  parameter int NUM = 15,
  parameter logic [CW-1:0] SYS_CODE = 12,
  parameter logic [CW-1:0] ILL_CODE = 7
) (
  input  logic [CW-1:0] cause_i,
  output logic          valid_o,
  output logic          is_sys_o,
  output logic          is_ill_o
);
  localparam int CNT_W = CW + 1;
  localparam logic [CNT_W-1:0] NUM_W = CNT_W'(NUM);

  assign valid_o  = (cause_i != '0) && ({1'b0, cause_i} < NUM_W);
  assign is_sys_o = (cause_i == SYS_CODE);
  assign is_ill_o = (cause_i == ILL_CODE);
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
  parameter int XLEN  = 32,
  parameter int CW    = 5,
  parameter int SHIFT = 8,
  parameter logic [XLEN-1:0] HIGH = 32'hF000_0000
) (
  input  logic [CW-1:0]   cause_i,
  input  logic [XLEN-1:0] base_i,
  input  logic            base_en_i,
  input  logic            high_i,
  output logic [XLEN-1:0] vec_o
);
  localparam int PAD = XLEN - CW - SHIFT;

  logic [XLEN-1:0] off, base_part, high_part;
  assign off       = {{PAD{1'b0}}, cause_i, {SHIFT{1'b0}}};
  assign base_part = base_en_i ? base_i : '0;
  assign high_part = high_i ? HIGH : '0;
  assign vec_o     = off | base_part | high_part;
endmodule

// File: rtl/exc_sr_upd.sv
module exc_sr_upd #(
  parameter int SR_W    = 16,
  parameter int SM_B    = 0,
  parameter int DSX_B   = 6,
  parameter logic [SR_W-1:0] CLR_MASK = 16'h001E
) (
  input  logic [SR_W-1:0] sr_i,
  input  logic            dslot_i,
  output logic [SR_W-1:0] esr_o,
  output logic [SR_W-1:0] sr_o
);
  for (genvar b = 0; b < SR_W; b++) begin : g_bit
    if (b == DSX_B) begin : g_dsx
      assign esr_o[b] = dslot_i;
    end else begin : g_keep
      assign esr_o[b] = sr_i[b];
    end
    if (b == SM_B) begin : g_set
      assign sr_o[b] = 1'b1;
    end else if (CLR_MASK[b]) begin : g_clr
      assign sr_o[b] = 1'b0;
    end else begin : g_pass
      assign sr_o[b] = esr_o[b];
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int P_XLEN = exc_pkg::XLEN,
  parameter int P_SR_W = exc_pkg::SR_W,
  parameter int P_PM_W = exc_pkg::PM_W,
  parameter int P_CW   = exc_pkg::CAUSE_W,
  parameter int P_NUM  = exc_pkg::NUM_CAUSES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_valid_i,
  input  logic [P_CW-1:0]   trap_cause_i,
  input  logic              irq_ext_i,
  input  logic              irq_tick_i,
  input  logic [P_XLEN-1:0] pc_i,
  input  logic              in_dslot_i,
  input  logic [P_SR_W-1:0] sr_i,
  input  logic [P_PM_W-1:0] pm_i,
  input  logic [P_XLEN-1:0] vbase_i,
  input  logic              vbase_en_i,
  output logic              entry_o,
  output logic              unhandled_o,
  output logic              tlb_flush_o,
  output logic [P_CW-1:0]   exc_cause_o,
  output logic [P_XLEN-1:0] pc_o,
  output logic [P_XLEN-1:0] epc_o,
  output logic [P_XLEN-1:0] eear_o,
  output logic [P_SR_W-1:0] esr_o,
  output logic [P_SR_W-1:0] sr_o,
  output logic [P_PM_W-1:0] pm_o,
  output logic [P_XLEN-1:0] ll_addr_o
);
  localparam logic [P_SR_W-1:0] SR_CLR =
    P_SR_W'((1 << TEE_BIT) | (1 << IEE_BIT) | (1 << DME_BIT) | (1 << IME_BIT));
  localparam logic [P_PM_W-1:0] PM_CLR = P_PM_W'((1 << DOZE_BIT) | (1 << SLP_BIT));
  localparam logic [P_XLEN-1:0] INSN_B = P_XLEN'(4);

  logic            arb_req;
  logic [P_CW-1:0] arb_cause, sel_cause;
  logic            go, c_valid, c_sys, c_ill, accept, bad;
  logic [P_XLEN-1:0] vec, epc_n, dec, inc;
  logic [P_SR_W-1:0] esr_n, sr_n;

  exc_irq_arb #(.CW(P_CW), .TICK_CODE(C_TICK), .EXT_CODE(C_EXT)) u_arb (
    .ext_i   (irq_ext_i),
    .tick_i  (irq_tick_i),
    .iee_i   (sr_i[IEE_BIT]),
    .tee_i   (sr_i[TEE_BIT]),
    .req_o   (arb_req),
    .cause_o (arb_cause)
  );

  // trap has priority; interrupt stays pending at its source
  assign sel_cause = trap_valid_i ? trap_cause_i : arb_cause;
  assign go        = trap_valid_i | arb_req;

  exc_cause_chk #(.CW(P_CW), .NUM(P_NUM), .SYS_CODE(C_SYSCALL), .ILL_CODE(C_ILLEGAL)) u_chk (
    .cause_i  (sel_cause),
    .valid_o  (c_valid),
    .is_sys_o (c_sys),
    .is_ill_o (c_ill)
  );

  exc_vec_gen #(.XLEN(P_XLEN), .CW(P_CW), .SHIFT(VEC_SHIFT), .HIGH(P_XLEN'(HIGH_PREFIX))) u_vec (
    .cause_i   (sel_cause),
    .base_i    (vbase_i),
    .base_en_i (vbase_en_i),
    .high_i    (sr_i[EPH_BIT]),
    .vec_o     (vec)
  );

  exc_sr_upd #(.SR_W(P_SR_W), .SM_B(SM_BIT), .DSX_B(DSX_BIT), .CLR_MASK(SR_CLR)) u_sr (
    .sr_i    (sr_i),
    .dslot_i (in_dslot_i),
    .esr_o   (esr_n),
    .sr_o    (sr_n)
  );

  assign accept = go & c_valid;
  assign bad    = go & ~c_valid;
  assign dec    = in_dslot_i ? INSN_B : '0;
  assign inc    = c_sys ? INSN_B : '0;
  assign epc_n  = pc_i - dec + inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_o     <= 1'b0;
      unhandled_o <= 1'b0;
      tlb_flush_o <= 1'b0;
      exc_cause_o <= '0;
      pc_o        <= '0;
      epc_o       <= '0;
      eear_o      <= '0;
      esr_o       <= '0;
      sr_o        <= '0;
      pm_o        <= '0;
      ll_addr_o   <= '0;
    end else begin
      entry_o     <= accept;
      unhandled_o <= bad;
      tlb_flush_o <= accept;
      if (accept) begin
        exc_cause_o <= sel_cause;
        pc_o        <= vec;
        epc_o       <= epc_n;
        esr_o       <= esr_n;
        sr_o        <= sr_n;
        pm_o        <= pm_i & ~PM_CLR;
        ll_addr_o   <= '1;
        if (c_ill) eear_o <= pc_i;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_pkg::*;
#(
  parameter int P_XLEN = 32,
  parameter int P_SR_W = 16,
  parameter int P_PM_W = 4,
  parameter int P_CW   = 5,
  parameter int P_NUM  = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trap_valid_i,
  input logic [P_CW-1:0]   trap_cause_i,
  input logic              irq_tick_i,
  input logic [P_XLEN-1:0] pc_i,
  input logic              in_dslot_i,
  input logic [P_SR_W-1:0] sr_i,
  input logic              entry_o,
  input logic              unhandled_o,
  input logic [P_CW-1:0]   exc_cause_o,
  input logic [P_XLEN-1:0] pc_o,
  input logic [P_XLEN-1:0] epc_o,
  input logic [P_SR_W-1:0] esr_o,
  input logic [P_SR_W-1:0] sr_o,
  input logic [P_PM_W-1:0] pm_o,
  input logic [P_XLEN-1:0] ll_addr_o
);
  logic ok_cause;
  assign ok_cause = (trap_cause_i != '0) && (32'(trap_cause_i) < P_NUM);

  AST_TRAP_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && ok_cause |=> entry_o && exc_cause_o == $past(trap_cause_i)); // R10

  AST_BAD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && !ok_cause |=> unhandled_o && !entry_o && $stable(pc_o)); // R8

  AST_SR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> sr_o[SM_BIT] && !sr_o[TEE_BIT] && !sr_o[IEE_BIT]
                && !sr_o[DME_BIT] && !sr_o[IME_BIT]); // R5

  AST_PM_LL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> !pm_o[DOZE_BIT] && !pm_o[SLP_BIT] && (&ll_addr_o)); // R6

  AST_TICK_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i && irq_tick_i && sr_i[TEE_BIT] |=> entry_o && exc_cause_o == C_TICK); // R9

  AST_SYSCALL_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && trap_cause_i == C_SYSCALL && !in_dslot_i |=> epc_o == $past(pc_i) + 4); // R2

  AST_ESR_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && ok_cause |=>
      esr_o[DSX_BIT] == $past(in_dslot_i) && esr_o[P_SR_W-1:DSX_BIT+1] == $past(sr_i[P_SR_W-1:DSX_BIT+1])
      && esr_o[DSX_BIT-1:0] == $past(sr_i[DSX_BIT-1:0])); // R4
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
  .P_XLEN(P_XLEN), .P_SR_W(P_SR_W), .P_PM_W(P_PM_W), .P_CW(P_CW), .P_NUM(P_NUM)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .trap_valid_i(trap_valid_i), .trap_cause_i(trap_cause_i),
  .irq_tick_i(irq_tick_i), .pc_i(pc_i), .in_dslot_i(in_dslot_i), .sr_i(sr_i),
  .entry_o(entry_o), .unhandled_o(unhandled_o), .exc_cause_o(exc_cause_o), .pc_o(pc_o),
  .epc_o(epc_o), .esr_o(esr_o), .sr_o(sr_o), .pm_o(pm_o), .ll_addr_o(ll_addr_o)
);

// File: tb/exc_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0;
  logic [4:0]  trap_cause = '0;
  logic        irq_ext = 1'b0, irq_tick = 1'b0;
  logic [31:0] pc = '0;
  logic        dslot = 1'b0;
  logic [15:0] sr = '0;
  logic [3:0]  pm = '0;
  logic [31:0] vbase = '0;
  logic        vbase_en = 1'b0;

  logic        entry, unh, flush;
  logic [4:0]  cause_o;
  logic [31:0] pc_o, epc_o, eear_o, ll_o;
  logic [15:0] esr_o, sr_o;
  logic [3:0]  pm_o;

  always #4 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(trap_valid), .trap_cause_i(trap_cause),
    .irq_ext_i(irq_ext), .irq_tick_i(irq_tick), .pc_i(pc), .in_dslot_i(dslot), .sr_i(sr),
    .pm_i(pm), .vbase_i(vbase), .vbase_en_i(vbase_en), .entry_o(entry), .unhandled_o(unh),
    .tlb_flush_o(flush), .exc_cause_o(cause_o), .pc_o(pc_o), .epc_o(epc_o), .eear_o(eear_o),
    .esr_o(esr_o), .sr_o(sr_o), .pm_o(pm_o), .ll_addr_o(ll_o)
  );

  typedef struct {
    logic        entry, unh, flush;
    logic [4:0]  cause;
    logic [31:0] pc, epc, eear;
    logic [15:0] esr, sr;
    logic [3:0]  pm;
    logic [31:0] ll;
    string       tag;
  } item_t;

  item_t q[$];
  item_t m;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic drive(input logic t, input logic [4:0] c, input logic ex, input logic tk,
                       input logic [31:0] p, input logic ds, input logic [15:0] s,
                       input logic [3:0] pmv, input logic [31:0] vb, input logic vbe,
                       input string tag);
    logic go;
    logic [4:0] sc;
    logic ok;
    @(negedge clk);
    trap_valid = t; trap_cause = c; irq_ext = ex; irq_tick = tk; pc = p; dslot = ds;
    sr = s; pm = pmv; vbase = vb; vbase_en = vbe;
    go = 1'b0; sc = '0;
    if (t) begin go = 1'b1; sc = c; end
    else if (tk && s[1]) begin go = 1'b1; sc = 5'd5; end
    else if (ex && s[2]) begin go = 1'b1; sc = 5'd8; end
    ok = go && sc != 0 && sc < 15;
    m.entry = ok; m.flush = ok; m.unh = go && !ok; m.tag = tag;
    if (ok) begin
      m.cause = sc;
      m.esr = s; m.esr[6] = ds;
      m.sr = (m.esr & ~16'h001E) | 16'h0001;
      m.epc = p - (ds ? 32'd4 : 32'd0) + ((sc == 5'd12) ? 32'd4 : 32'd0);
      if (sc == 5'd7) m.eear = p;
      m.pm = pmv & ~4'h3;
      m.ll = '1;
      m.pc = {19'd0, sc, 8'd0} | (vbe ? vb : 32'd0) | (s[5] ? 32'hF000_0000 : 32'd0);
    end
    q.push_back(m);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 5'd0, 1'b0, 1'b0, 32'h0, 1'b0, 16'h0000, 4'h0, 32'h0, 1'b0, tag);
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_run++;
        if ({entry, unh, flush, cause_o, pc_o, epc_o, eear_o, esr_o, sr_o, pm_o, ll_o} !==
            {e.entry, e.unh, e.flush, e.cause, e.pc, e.epc, e.eear, e.esr, e.sr, e.pm, e.ll}) begin
          n_fail++;
          $display("FAIL %s act ent=%b unh=%b fl=%b c=%0d pc=%h epc=%h eear=%h esr=%h sr=%h pm=%h ll=%h exp ent=%b unh=%b fl=%b c=%0d pc=%h epc=%h eear=%h esr=%h sr=%h pm=%h ll=%h",
                   e.tag, entry, unh, flush, cause_o, pc_o, epc_o, eear_o, esr_o, sr_o, pm_o, ll_o,
                   e.entry, e.unh, e.flush, e.cause, e.pc, e.epc, e.eear, e.esr, e.sr, e.pm, e.ll);
        end
      end
    end
  end

  initial begin : watchdog
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    m = '{entry:0, unh:0, flush:0, cause:0, pc:0, epc:0, eear:0, esr:0, sr:0, pm:0, ll:0, tag:""};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_run++;  // R11 reset values
    if ({entry, unh, flush, cause_o, pc_o, epc_o, eear_o, esr_o, sr_o, pm_o, ll_o} !== '0) begin
      n_fail++;
      $display("FAIL R11 reset act pc=%h ll=%h sr=%h exp all zero", pc_o, ll_o, sr_o);
    end

    drive(1, 5'd12, 0, 0, 32'h0000_1000, 0, 16'h001F, 4'hF, 32'h0, 0, "R2 syscall");
    idle("R11 pulse ends");
    drive(1, 5'd12, 0, 0, 32'h0000_2004, 1, 16'h8006, 4'h5, 32'h0, 0, "R1 R2 syscall in delay slot");
    drive(1, 5'd2, 0, 0, 32'h0000_3000, 1, 16'hFFBF, 4'hA, 32'h0, 0, "R1 R3 R4 R5 delay slot, eear held");
    drive(1, 5'd7, 0, 0, 32'h0000_4440, 0, 16'hFFFF, 4'h7, 32'h0, 0, "R3 illegal loads eear");
    drive(1, 5'd3, 0, 0, 32'h0000_5550, 0, 16'h0040, 4'h3, 32'h0, 0, "R3 R4 eear kept, dsx cleared");
    drive(1, 5'd9, 0, 0, 32'h0000_6000, 0, 16'h0020, 4'hC, 32'h0012_0000, 1, "R7 base and high prefix");
    drive(1, 5'd14, 0, 0, 32'h0000_6100, 0, 16'h0000, 4'h0, 32'h0034_0000, 0, "R7 base absent");
    drive(1, 5'd0, 0, 0, 32'h0000_7000, 0, 16'h0006, 4'hF, 32'h0, 0, "R8 cause zero");
    drive(1, 5'd15, 0, 0, 32'h0000_7100, 1, 16'h0006, 4'hF, 32'h0, 0, "R8 cause at limit");
    drive(1, 5'd31, 0, 0, 32'h0000_7200, 0, 16'h0006, 4'hF, 32'h0, 0, "R8 cause max");
    idle("R8 pulse ends");
    drive(0, 5'd0, 0, 1, 32'h0000_8000, 0, 16'h0002, 4'hF, 32'h0, 0, "R9 tick enabled");
    drive(0, 5'd0, 0, 1, 32'h0000_8100, 0, 16'h0004, 4'hF, 32'h0, 0, "R9 tick masked");
    drive(0, 5'd0, 1, 1, 32'h0000_8200, 0, 16'h0006, 4'h1, 32'h0, 0, "R9 both pending, tick wins");
    drive(0, 5'd0, 1, 1, 32'h0000_8300, 0, 16'h0004, 4'h2, 32'h0, 0, "R9 only ext qualifies");
    drive(0, 5'd0, 1, 0, 32'h0000_8400, 0, 16'h0002, 4'h2, 32'h0, 0, "R9 ext masked");
    drive(1, 5'd11, 1, 1, 32'h0000_9000, 0, 16'h0006, 4'hF, 32'h0, 0, "R10 trap beats interrupt");
    drive(0, 5'd0, 1, 1, 32'h0000_9004, 0, 16'h0006, 4'hF, 32'h0, 0, "R10 pending interrupt taken next");
    drive(1, 5'd12, 1, 0, 32'h0000_9100, 1, 16'h0024, 4'hB, 32'h00A0_0000, 1, "R6 R10 syscall over ext");
    drive(1, 5'd1, 0, 0, 32'h0000_9200, 0, 16'hFFFF, 4'hF, 32'hFFFF_0000, 1, "R5 R6 R7 all bits set");
    idle("R11 idle after entries");
    idle("R11 idle holds");

    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule